// File: doc/BRIEF.md
# Pending Interrupt Wakeup Filter

When a reschedule request arrives, this block decides whether pending interrupt wakeups need a software handler, or whether execution can simply resume. It holds a new-wakeups register. It drops a legacy key bit from that register, then sorts the request into one of four outcomes. A lone language key bit produces a keyboard punt. An empty or non-positive register produces the no-interrupt outcome. Any other pattern starts the full wakeup path.

On the full path the block fetches two words through a simple memory port: the waiting-wakeups word at a base address, and the active-channels word at the next address. It merges the waiting and new wakeups, masks the merge with the active channels, and stores the masked value back in the register. A nonzero mask raises a general wakeup punt. A zero mask means every pending wakeup belongs to a channel that is switched off. In that case the merged word is written back to the waiting address, so those wakeups are deferred, and execution resumes.

Reads use a request/valid handshake and the write uses a request/acknowledge handshake. Either may take any number of cycles. Each request ends in a single one-cycle outcome pulse.

Top module: `wakeup_filter`

## Requirements
- R1: After reset all request and outcome outputs are 0 and `wake_o` is 0.
- R2: In idle with `req_i` low, `load_i` copies `load_data_i` into the new-wakeups register, which is visible on `wake_o` the next cycle. A load while a request is in progress has no effect.
- R3: If the register is zero or has its top bit set (non-positive as a signed value) when a request is taken, the outcome is no-interrupt (`none_o`). The register is unchanged and no memory access occurs.
- R4: Otherwise bit `LEGACY_BIT` (default bit 0) of the register is cleared, whatever the outcome.
- R5: After that clear, a register of zero gives `none_o`. A register whose only set bit is `KEY_BIT` (default bit 1) gives `key_punt_o`. Neither case makes a memory access.
- R6: In all other cases the block reads `WAIT_ADDR`, then `WAIT_ADDR+1`. It holds `rd_req_o` and `rd_addr_o` steady until `rd_valid_i`.
- R7: The register then becomes (waiting OR cleared-new) AND active.
- R8: If that value is nonzero, `wake_punt_o` pulses and no write occurs.
- R9: If that value is zero, the block writes (waiting OR cleared-new) to `WAIT_ADDR`. It holds `wr_req_o`, `wr_addr_o` and `wr_data_o` steady until `wr_ack_i`, then pulses `resume_o`.
- R10: Each request yields exactly one single-cycle pulse on exactly one outcome output. `req_i` is ignored until that pulse has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Reschedule request, taken in idle |
| load_i | input | 1 | Load new-wakeups register |
| load_data_i | input | DATA_W | Value to load |
| wake_o | output | DATA_W | New-wakeups register |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DATA_W | Read data |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| none_o | output | 1 | Outcome: no interrupt |
| key_punt_o | output | 1 | Outcome: keyboard punt |
| wake_punt_o | output | 1 | Outcome: general wakeup punt |
| resume_o | output | 1 | Outcome: resume after deferral |

## Verification
The assertions assume that `rd_valid_i` rises only while `rd_req_o` is high and `wr_ack_i` only while `wr_req_o` is high, each for a single cycle per access. The bench memory model raises valid and acknowledge only in answer to a visible request, after a chosen delay of zero to four cycles, and drops them on the following cycle. Register values are drawn so that every outcome class comes up often: sign bit set, empty, legacy bit only, key bit only, and general patterns whose active mask is chosen either to hit or to miss. Requests and loads are also injected while a request is in progress, and these must be ignored.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_WAIT, ST_RD_ACT, ST_WR, ST_DONE
  } wf_state_e;

  localparam int unsigned OUT_N = 4;
  localparam logic [1:0] OUT_NONE   = 2'd0;
  localparam logic [1:0] OUT_KEY    = 2'd1;
  localparam logic [1:0] OUT_WAKE   = 2'd2;
  localparam logic [1:0] OUT_RESUME = 2'd3;
endpackage

// File: rtl/wf_classify.sv
module wf_classify #(
  parameter int unsigned W          = 16,
  parameter int unsigned LEGACY_BIT = 0,
  parameter int unsigned KEY_BIT    = 1
) (
  input  logic [W-1:0] wake_i,
  output logic         skip_o,
  output logic [W-1:0] cleared_o,
  output logic         empty_o,
  output logic         key_only_o
);
  localparam logic [W-1:0] LEG_MASK = W'(1) << LEGACY_BIT;
  localparam logic [W-1:0] KEY_MASK = W'(1) << KEY_BIT;

  always_comb begin
    skip_o     = wake_i[W-1] || (wake_i == '0);
    cleared_o  = wake_i & ~LEG_MASK;
    empty_o    = (cleared_o == '0);
    key_only_o = !empty_o && ((cleared_o & ~KEY_MASK) == '0);
  end
endmodule

// File: rtl/wf_merge.sv
module wf_merge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] waiting_i,
  input  logic [W-1:0] wake_i,
  input  logic [W-1:0] active_i,
  output logic [W-1:0] merged_o,
  output logic [W-1:0] masked_o,
  output logic         hit_o
);
  always_comb begin
    merged_o = waiting_i | wake_i;
    masked_o = merged_o & active_i;
    hit_o    = |masked_o;
  end
endmodule

// File: rtl/wf_pulse.sv
module wf_pulse #(
  parameter int unsigned N = 4
) (
  input  logic                 fire_i,
  input  logic [$clog2(N)-1:0] sel_i,
  output logic [N-1:0]         pulse_o
);
  for (genvar g = 0; g < N; g++) begin : g_out
    assign pulse_o[g] = fire_i && (sel_i == ($clog2(N))'(g));
  end
endmodule

// File: rtl/wakeup_filter.sv
module wakeup_filter #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] WAIT_ADDR = 'h012A,
  parameter int unsigned LEGACY_BIT = 0,
  parameter int unsigned KEY_BIT    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic [DATA_W-1:0] wake_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              none_o,
  output logic              key_punt_o,
  output logic              wake_punt_o,
  output logic              resume_o
);
  import wf_pkg::*;

  localparam logic [ADDR_W-1:0] ACT_ADDR = WAIT_ADDR + ADDR_W'(1);
  localparam int unsigned SEL_W = $clog2(OUT_N);

  wf_state_e         state_q;
  logic [DATA_W-1:0] wake_q, ww_q, merged_q;
  logic [SEL_W-1:0]  outcome_q;

  logic              skip, empty, key_only, hit;
  logic [DATA_W-1:0] cleared, merged, masked;
  logic [OUT_N-1:0]  pulses;

  wf_classify #(.W(DATA_W), .LEGACY_BIT(LEGACY_BIT), .KEY_BIT(KEY_BIT)) u_classify (
    .wake_i(wake_q), .skip_o(skip), .cleared_o(cleared),
    .empty_o(empty), .key_only_o(key_only)
  );

  wf_merge #(.W(DATA_W)) u_merge (
    .waiting_i(ww_q), .wake_i(wake_q), .active_i(rd_data_i),
    .merged_o(merged), .masked_o(masked), .hit_o(hit)
  );

  wf_pulse #(.N(OUT_N)) u_pulse (
    .fire_i(state_q == ST_DONE), .sel_i(outcome_q), .pulse_o(pulses)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wake_q    <= '0;
      ww_q      <= '0;
      merged_q  <= '0;
      outcome_q <= OUT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (skip) begin
              outcome_q <= OUT_NONE;
              state_q   <= ST_DONE;
            end else begin
              wake_q <= cleared;
              if (empty) begin
                outcome_q <= OUT_NONE;
                state_q   <= ST_DONE;
              end else if (key_only) begin
                outcome_q <= OUT_KEY;
                state_q   <= ST_DONE;
              end else begin
                state_q <= ST_RD_WAIT;
              end
            end
          end else if (load_i) begin
            wake_q <= load_data_i;
          end
        end
        ST_RD_WAIT: if (rd_valid_i) begin
          ww_q    <= rd_data_i;
          state_q <= ST_RD_ACT;
        end
        ST_RD_ACT: if (rd_valid_i) begin
          wake_q   <= masked;
          merged_q <= merged;
          if (hit) begin
            outcome_q <= OUT_WAKE;
            state_q   <= ST_DONE;
          end else begin
            state_q <= ST_WR;
          end
        end
        ST_WR: if (wr_ack_i) begin
          outcome_q <= OUT_RESUME;
          state_q   <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wake_o      = wake_q;
  assign rd_req_o    = (state_q == ST_RD_WAIT) || (state_q == ST_RD_ACT);
  assign rd_addr_o   = (state_q == ST_RD_ACT) ? ACT_ADDR : WAIT_ADDR;
  assign wr_req_o    = (state_q == ST_WR);
  assign wr_addr_o   = WAIT_ADDR;
  assign wr_data_o   = merged_q;
  assign none_o      = pulses[OUT_NONE];
  assign key_punt_o  = pulses[OUT_KEY];
  assign wake_punt_o = pulses[OUT_WAKE];
  assign resume_o    = pulses[OUT_RESUME];

  // R10
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({none_o, key_punt_o, wake_punt_o, resume_o}));

  // R10
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (none_o || key_punt_o || wake_punt_o || resume_o) |=>
    !(none_o || key_punt_o || wake_punt_o || resume_o));

  // R6
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R9
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o) && $stable(wr_addr_o)));

  // R9
  no_rd_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  // R4
  legacy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i && !wake_o[DATA_W-1] && wake_o != '0)
    |=> !wake_o[LEGACY_BIT]);

  // R8
  wake_punt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_punt_o |-> (wake_o != '0));

  // R9
  resume_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (wake_o == '0));
endmodule

// File: tb/wakeup_filter_test.sv
`timescale 1ns/1ps
module wakeup_filter_test;
  localparam logic [15:0] WADDR = 16'h012A;
  localparam logic [15:0] LEG   = 16'h0001;
  localparam logic [15:0] KEY   = 16'h0002;

  logic        clk = 0, rst_n = 0;
  logic        req_i = 0, load_i = 0, rd_valid_i = 0, wr_ack_i = 0;
  logic [15:0] load_data_i = 0, rd_data_i = 0;
  logic [15:0] wake_o, rd_addr_o, wr_addr_o, wr_data_o;
  logic        rd_req_o, wr_req_o, none_o, key_punt_o, wake_punt_o, resume_o;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wakeup_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req_i), .load_i(load_i),
    .load_data_i(load_data_i), .wake_o(wake_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ack_i(wr_ack_i), .none_o(none_o), .key_punt_o(key_punt_o),
    .wake_punt_o(wake_punt_o), .resume_o(resume_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outcome codes: 0 none, 1 key, 2 wake, 3 resume
  function automatic void model(input logic [15:0] n, ww, act, output int oc,
                                output logic [15:0] fin, output int nrd,
                                output bit wr, output logic [15:0] wd);
    logic [15:0] c, m;
    nrd = 0; wr = 0; wd = 0;
    if (n[15] || n == 0) begin oc = 0; fin = n; return; end
    c = n & ~LEG;
    if (c == 0) begin oc = 0; fin = c; return; end
    if (c == KEY) begin oc = 1; fin = c; return; end
    nrd = 2; m = ww | c; fin = m & act;
    if (fin != 0) oc = 2;
    else begin oc = 3; wr = 1; wd = m; end
  endfunction

  task automatic run_case(input logic [15:0] n, ww, act, input bit inject, input int dly);
    int oc, nrd, pulses, got, rds, wrs, rcnt, wcnt, after;
    logic [15:0] fin, wd, wdata, waddr;
    bit wr, addr_bad;
    string tag;
    model(n, ww, act, oc, fin, nrd, wr, wd);
    tag = (oc == 1) ? "R5" : (oc == 2) ? "R8" : (oc == 3) ? "R9" :
          (n[15] || n == 0) ? "R3" : "R5";
    @(negedge clk); load_i = 1; load_data_i = n;
    @(negedge clk); load_i = 0;
    chk(wake_o == n, "R2 load", wake_o, n);
    req_i = 1;
    @(negedge clk);
    pulses = 0; got = -1; rds = 0; wrs = 0; rcnt = dly; wcnt = dly;
    after = -1; addr_bad = 0; wdata = 0; waddr = 0;
    for (int cyc = 0; cyc < 80; cyc++) begin
      req_i = inject && cyc == 0;
      load_i = inject && cyc == 0;
      load_data_i = 16'(~n);
      if (none_o)      begin pulses++; got = 0; end
      if (key_punt_o)  begin pulses++; got = 1; end
      if (wake_punt_o) begin pulses++; got = 2; end
      if (resume_o)    begin pulses++; got = 3; end
      if (rd_valid_i) begin rd_valid_i = 0; rcnt = dly; end
      else if (rd_req_o) begin
        if (rcnt == 0) begin
          rd_valid_i = 1; rds++;
          if (rds == 1 && rd_addr_o != WADDR) addr_bad = 1;
          if (rds == 2 && rd_addr_o != WADDR + 16'd1) addr_bad = 1;
          rd_data_i = (rd_addr_o == WADDR) ? ww : act;
        end else rcnt--;
      end
      if (wr_ack_i) begin wr_ack_i = 0; wcnt = dly; end
      else if (wr_req_o) begin
        if (wcnt == 0) begin
          wr_ack_i = 1; wrs++; wdata = wr_data_o; waddr = wr_addr_o;
        end else wcnt--;
      end
      if (pulses > 0 && after < 0) after = cyc;
      if (after >= 0 && cyc >= after + 3) break;
      @(negedge clk);
    end
    req_i = 0; load_i = 0; rd_valid_i = 0; wr_ack_i = 0;
    chk(pulses == 1, "R10 pulse count", pulses, 1);
    chk(got == oc, {tag, " outcome"}, got, oc);
    chk(wake_o == fin, (oc >= 2) ? "R7 register" : "R4 register", wake_o, fin);
    chk(rds == nrd && !addr_bad, "R6 reads", rds, nrd);
    chk(wrs == int'(wr), "R9 write count", wrs, wr);
    if (wr) chk(wdata == wd && waddr == WADDR, "R9 write data", wdata, wd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] n, ww, act;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk({rd_req_o, wr_req_o, none_o, key_punt_o, wake_punt_o, resume_o} == 0,
        "R1 outputs", {rd_req_o, wr_req_o, none_o, key_punt_o, wake_punt_o, resume_o}, 0);
    chk(wake_o == 0, "R1 register", wake_o, 0);
    // directed corners
    run_case(16'h8000, 16'h0, 16'hFFFF, 0, 0);  // R3 sign bit
    run_case(16'h0000, 16'h0, 16'hFFFF, 1, 0);  // R3 zero
    run_case(LEG,      16'h0, 16'hFFFF, 0, 1);  // R4 legacy only
    run_case(KEY | LEG,16'h0, 16'hFFFF, 1, 0);  // R4 R5 key punt
    run_case(KEY,      16'h0, 16'hFFFF, 0, 2);  // R5
    run_case(16'h0010, 16'h0100, 16'h0100, 1, 3); // R8 via waiting word
    run_case(16'h0011, 16'h0300, 16'h0000, 1, 4); // R9 resume
    run_case(16'h7FFF, 16'h8000, 16'h8000, 0, 0); // R8 top bit from waiting
    for (int i = 0; i < 300; i++) begin
      int mode = $urandom_range(0, 5);
      n = 16'($urandom); ww = 16'($urandom); act = 16'($urandom);
      case (mode)
        0: n[15] = 1'b1;
        1: n = 16'($urandom_range(0, 3));
        2: begin n[15] = 1'b0; act = ~(ww | (n & ~LEG)); end
        default: n[15] = 1'b0;
      endcase
      run_case(n, ww, act, 1'($urandom_range(0, 1)), $urandom_range(0, 4));
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule